// File: doc/BRIEF.md
# Reversible Block Update Cell

This cell holds one 2x2 block of a reversible, billiard-ball style cellular automaton. Each cycle it can accept a four-bit block, push it through a short register pipeline, and present the updated block for the alternate bit-plane three register stages later. The four corners are packed into one vector. Bit 0 is corner A, bit 1 is B, bit 2 is C and bit 3 is D, going around the block. A and C are diagonal partners, and so are B and D.

The update treats any block with a 1 on both diagonals as fixed, so it is copied unchanged. A single set bit jumps to the opposite corner. A pair of set bits that share one diagonal moves onto the other diagonal. An empty block stays empty. The rule does not depend on orientation and it undoes itself when applied twice. For loading an array, a shift control bypasses the rule and sends every bit to its opposite corner. A whole array of these cells then behaves as one long shift register. A valid flag travels alongside the data.

Top module: `bbm_block_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the next output has `out_valid` = 0 and `out_blk` = 4'b0000.
- R2: A block sampled at clock edge N is reflected on `out_blk` and `out_valid` right after edge N+2 (three register stages). `out_valid` repeats `in_valid` with that delay, and the data is processed whatever the value of `in_valid`.
- R3: With `shift_en` = 0, a block with (A or C) and (B or D) true is output unchanged. This covers every block with three or four set bits and every pair of adjacent set bits.
- R4: With `shift_en` = 0, a block with exactly one set bit outputs that bit at the diagonally opposite corner (A<->C, B<->D).
- R5: With `shift_en` = 0, 4'b0101 (A and C) becomes 4'b1010 (B and D), and 4'b1010 becomes 4'b0101.
- R6: With `shift_en` = 0, 4'b0000 stays 4'b0000.
- R7: With `shift_en` = 1, each output corner takes the input bit from its opposite corner (out[0]=in[2], out[1]=in[3], out[2]=in[0], out[3]=in[1]) for every block value.
- R8: With `shift_en` = 0, feeding a block's output back in as a new input reproduces the original block, for all 16 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the presented block as meaningful |
| shift_en | input | 1 | 1 selects the corner-to-corner load path |
| in_blk | input | 4 | Block corners {D,C,B,A} |
| out_valid | output | 1 | Delayed copy of in_valid |
| out_blk | output | 4 | Updated block corners {D,C,B,A} |

## Verification
The embedded properties expect `shift_en` and `in_blk` to be stable across each clock edge, and they expect reset to be held for at least one edge before any checked traffic. They also expect `shift_en` to apply per sample rather than per array, so it may change on any cycle. The stimulus changes inputs only at falling edges and holds reset for several cycles. It mixes shift and rule traffic cycle by cycle, and it toggles `in_valid` in a pattern so that the valid delay can be seen apart from the data.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int CORNERS = 4;
    localparam int STAGES  = 3;
    localparam int HALF    = CORNERS / 2;

    typedef logic [CORNERS-1:0] blk_t;

    typedef struct packed {
        logic valid;
        logic shift;
        logic hold;
        blk_t bits;
    } s1_t;

    typedef struct packed {
        logic valid;
        logic shift;
        blk_t raw;
        blk_t upd;
    } s2_t;

    typedef struct packed {
        logic valid;
        blk_t bits;
    } s3_t;

    function automatic blk_t opposite(input blk_t b);
        blk_t r;
        for (int i = 0; i < CORNERS; i++) r[i] = b[(i + HALF) % CORNERS];
        return r;
    endfunction

    function automatic logic both_diagonals(input blk_t b);
        return (b[0] | b[2]) & (b[1] | b[3]);
    endfunction

endpackage

// File: rtl/bbm_capture.sv
module bbm_capture
    import bbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic shift_en,
    input  blk_t in_blk,
    output s1_t  s1
);
    s1_t s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= in_valid;
            s1_q.shift <= shift_en;
            s1_q.hold  <= shift_en | both_diagonals(in_blk);
            s1_q.bits  <= in_blk;
        end
    end

    assign s1 = s1_q;

    // R7: load mode must freeze the rule stage
    a_r7_shift_holds: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> s1_q.hold);

endmodule

// File: rtl/bbm_rule.sv
module bbm_rule
    import bbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s1_t  s1,
    output s2_t  s2
);
    blk_t moved;
    s2_t  s2_q;

    for (genvar i = 0; i < CORNERS; i++) begin : g_corner
        localparam int OPP = (i + HALF) % CORNERS;
        localparam int NXT = (i + 1) % CORNERS;
        localparam int PRV = (i + CORNERS - 1) % CORNERS;
        assign moved[i] = s1.hold ? s1.bits[i]
                        : ((s1.bits[OPP] & ~s1.bits[i]) | (s1.bits[NXT] & s1.bits[PRV]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.valid <= s1.valid;
            s2_q.shift <= s1.shift;
            s2_q.raw   <= s1.bits;
            s2_q.upd   <= moved;
        end
    end

    assign s2 = s2_q;

    // R3: a held block passes through untouched
    a_r3_static_passes: assert property (@(posedge clk) disable iff (rst)
        s1.hold |=> s2_q.upd == $past(s1.bits));

    // R4: the rule neither creates nor destroys balls
    a_r4_ones_conserved: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(s2_q.upd) == $past($countones(s1.bits)));

endmodule

// File: rtl/bbm_emit.sv
module bbm_emit
    import bbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s2_t  s2,
    output s3_t  s3
);
    s3_t s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_q <= '0;
        end else begin
            s3_q.valid <= s2.valid;
            s3_q.bits  <= s2.shift ? opposite(s2.raw) : s2.upd;
        end
    end

    assign s3 = s3_q;

    // R7: load path swaps each corner with its diagonal partner
    a_r7_shift_rotates: assert property (@(posedge clk) disable iff (rst)
        s2.shift |=> s3_q.bits == opposite($past(s2.raw)));

endmodule

// File: rtl/bbm_block_cell.sv
module bbm_block_cell
    import bbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       shift_en,
    input  logic [3:0] in_blk,
    output logic       out_valid,
    output logic [3:0] out_blk
);
    s1_t s1;
    s2_t s2;
    s3_t s3;

    bbm_capture u_capture (
        .clk(clk), .rst(rst), .in_valid(in_valid), .shift_en(shift_en),
        .in_blk(in_blk), .s1(s1)
    );

    bbm_rule u_rule (.clk(clk), .rst(rst), .s1(s1), .s2(s2));

    bbm_emit u_emit (.clk(clk), .rst(rst), .s2(s2), .s3(s3));

    assign out_valid = s3.valid;
    assign out_blk   = s3.bits;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                  age_q <= '0;
        else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
    end

    // R1: reset empties the output register
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_blk == 4'b0000));

    // R2: valid flag arrives three edges after it was sampled
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> out_valid == $past(in_valid, 3));

endmodule

// File: tb/tb_bbm_block_cell.sv
module tb_bbm_block_cell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       shift_en = 1'b0;
    logic [3:0] in_blk = 4'b0;
    logic       out_valid;
    logic [3:0] out_blk;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [3:0] last_out;
    bit done = 0;

    always #2 clk = ~clk;

    bbm_block_cell dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .shift_en(shift_en),
        .in_blk(in_blk), .out_valid(out_valid), .out_blk(out_blk)
    );

    function automatic logic [3:0] model(input logic [3:0] b, input logic sh);
        int ones;
        ones = 0;
        for (int i = 0; i < 4; i++) ones += b[i];
        if (sh) return {b[1], b[0], b[3], b[2]};
        if (ones == 1) return {b[1], b[0], b[3], b[2]};
        if (b == 4'b0101) return 4'b1010;
        if (b == 4'b1010) return 4'b0101;
        return b;
    endfunction

    function automatic string tag(input logic [3:0] b, input logic sh);
        int ones;
        ones = 0;
        for (int i = 0; i < 4; i++) ones += b[i];
        if (sh) return "R7";
        if (b == 4'b0000) return "R6";
        if (ones == 1) return "R4";
        if (b == 4'b0101 || b == 4'b1010) return "R5";
        return "R3";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare after rising edge
    task automatic step(input logic [3:0] b, input logic sh, input logic v);
        int e;
        in_blk = b; shift_en = sh; in_valid = v;
        exp_q.push_back({v, model(b, sh), 8'(0)} | (tag(b, sh) == "R7" ? 1 : 0));
        @(posedge clk);
        @(negedge clk);
        e = exp_q.pop_front();
        check("R2 valid", out_valid, e[12]);
        check("R3-R7 data", out_blk, e[11:8]);
        last_out = out_blk;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 valid", out_valid, 0);
        check("R1 data", out_blk, 0);
        rst = 1'b0;
        exp_q.push_back(0);
        exp_q.push_back(0);

        for (int p = 0; p < 16; p++) step(4'(p), 1'b0, 1'b1);
        for (int p = 0; p < 16; p++) step(4'(p), 1'b1, 1'b1);
        for (int p = 0; p < 24; p++) step(4'(p * 7), 1'(p % 3 == 0), 1'(p % 2));

        // R5 and R6 explicit corners through the stream
        step(4'b0101, 1'b0, 1'b1); step(4'b1010, 1'b0, 1'b1); step(4'b0000, 1'b0, 1'b1);

        // R8: apply the rule twice
        for (int p = 0; p < 16; p++) begin
            logic [3:0] first;
            step(4'(p), 1'b0, 1'b1); step(4'b0, 1'b0, 1'b0); step(4'b0, 1'b0, 1'b0);
            first = last_out;
            step(first, 1'b0, 1'b1); step(4'b0, 1'b0, 1'b0); step(4'b0, 1'b0, 1'b0);
            check("R8 involution", last_out, p);
        end

        // R1 mid-run reset
        step(4'b0001, 1'b0, 1'b1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset valid", out_valid, 0);
        check("R1 reset data", out_blk, 0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule